// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit memory-mapped control register together with the sequencing logic that acts on its contents. Software writes one byte to request a processor power-saving state: stop, sleep, or time-base-timer mode. The same byte can also request a short internal reset pulse. It sets whether the external pins float while the part is in a deep mode. It selects how many CPU clock pulses are suppressed after each instruction, which gives intermittent CPU operation.

The mode request bits act as triggers rather than stored values. Stop and sleep are requested by writing 1 and always read back as 0. Time-base-timer mode and the internal reset are requested by writing 0 to active-low bits, and both of those bits always read back as 1. Any interrupt request returns the block to run mode. A current-clock-mode input decides whether time-base-timer mode may be entered. An instruction-complete strobe starts the clock-suppression window, and the window is driven out as a CPU clock enable.

Top module: `pwr_mode_ctl`

## Requirements
- R1: A write with bit 7 set enters stop mode (`stop_mode` high from the cycle after the write), and bit 7 of `rd_data` always reads 0.
- R2: A write with bit 6 set enters sleep mode and bit 6 always reads 0. If bits 7 and 6 are both set in one write, stop mode is entered and sleep is not.
- R3: A write with bit 3 clear enters time-base-timer mode only when `clk_mode` is 2'b00 (main clock) or 2'b01 (PLL clock). In 2'b10 or 2'b11 the request is ignored. Bit 3 always reads 1.
- R4: An interrupt request (`irq` high at a clock edge) returns the block to run mode at that edge. This also applies when the same edge carries a mode-entry write, so that entry is cancelled.
- R5: A write that requests no mode (bit 7 = 0, bit 6 = 0, bit 3 = 1) leaves the current mode unchanged.
- R6: Bit 5 is a stored pin-float flag that reads back as written. `pin_hiz` is high only when that flag is 1 and the block is in stop or time-base-timer mode; in sleep or run mode the pins are not floated.
- R7: A write with bit 4 clear drives `int_rst` high for exactly three clock cycles starting the cycle after the write. At that same edge the mode returns to run and bits 5 and 2:1 return to 0. Writes made while the pulse is active have no effect and do not extend it. Bit 4 always reads 1.
- R8: Bits 2:1 select the CPU halt length: 00 = none, 01 = 8, 10 = 16, 11 = 32 cycles. After `instr_done` is sampled high, `cpu_clk_en` is low for exactly that many cycles.
- R9: After reset the block is in run mode with `pin_hiz` low, `int_rst` low, `cpu_clk_en` high, and `rd_data` = 8'h18. Bit 0 always reads 0.
- R10: At most one of `stop_mode`, `sleep_mode` and `tbt_mode` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU/machine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| irq | input | 1 | Interrupt request, any source |
| clk_mode | input | 2 | Current clock mode: 00 main, 01 PLL, 10 sub, 11 other |
| instr_done | input | 1 | Instruction-complete strobe |
| stop_mode | output | 1 | Stop mode active |
| sleep_mode | output | 1 | Sleep mode active |
| tbt_mode | output | 1 | Time-base-timer mode active |
| pin_hiz | output | 1 | External pins to high impedance |
| int_rst | output | 1 | Internal reset pulse |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
The hardest situation to reach is a write that arrives while the internal reset pulse is still running. Such a write must neither restart the pulse nor change any state. The stimulus first loads non-reset values into every field, then triggers the pulse. On each following cycle it issues a fresh write: one with bit 4 clear and one requesting stop mode. It checks the outputs cycle by cycle until the pulse ends. Cancellation of a mode entry by an interrupt on the same edge is driven by raising `irq` and `wr_en` in the same cycle.

// File: rtl/pwr_mode_pkg.sv
// Package: shared types and bit positions for the low-power mode control register.
// Assumes an 8-bit register; positions are fixed because software decodes them.
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_TBT   = 2'b10,
        MODE_STOP  = 2'b11
    } pmc_mode_e;

    localparam logic [1:0] CLK_MAIN = 2'b00;
    localparam logic [1:0] CLK_PLL  = 2'b01;

    localparam int BIT_STOP  = 7;
    localparam int BIT_SLEEP = 6;
    localparam int BIT_FLOAT = 5;
    localparam int BIT_NRST  = 4;
    localparam int BIT_NTBT  = 3;
    localparam int BIT_HLT_H = 2;
    localparam int BIT_HLT_L = 1;

endpackage

// File: rtl/pmc_ctrl_reg.sv
// Module: pmc_ctrl_reg
// Holds the mode state, the pin-float flag and the halt-length field.
// Applies the entry priority stop > sleep > time-base-timer and lets an
// interrupt win over any entry on the same edge. While the internal reset
// pulse runs, every write is dropped and all state stays at reset values.
// Assumes wr_data is valid whenever wr_en is high.
module pmc_ctrl_reg
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       irq,
    input  logic [1:0] clk_mode,
    input  logic       rst_busy,
    output pmc_mode_e  mode,
    output logic       float_q,
    output logic [1:0] halt_sel,
    output logic       rst_trig
);

    logic      clk_ok;
    logic      req_stop;
    logic      req_sleep;
    logic      req_tbt;
    logic      any_req;
    pmc_mode_e next_entry;
    logic      unused_bits;

    assign unused_bits = wr_data[0];

    // Time-base-timer entry is legal only on the main or PLL clock.
    assign clk_ok = (clk_mode == CLK_MAIN) || (clk_mode == CLK_PLL);

    // Decode the individual requests carried by a write.
    always_comb begin
        req_stop  = wr_en && wr_data[BIT_STOP];
        req_sleep = wr_en && wr_data[BIT_SLEEP];
        req_tbt   = wr_en && !wr_data[BIT_NTBT] && clk_ok;
        any_req   = req_stop || req_sleep || req_tbt;
        rst_trig  = wr_en && !wr_data[BIT_NRST] && !rst_busy;
    end

    // Pick the mode a write asks for, highest priority first.
    always_comb begin
        if (req_stop)       next_entry = MODE_STOP;
        else if (req_sleep) next_entry = MODE_SLEEP;
        else if (req_tbt)   next_entry = MODE_TBT;
        else                next_entry = mode;
    end

    // Register update: reset, reset-pulse clear, interrupt exit, or write.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_busy || rst_trig) begin
            mode     <= MODE_RUN;
            float_q  <= 1'b0;
            halt_sel <= 2'b00;
        end else begin
            if (wr_en) begin
                float_q  <= wr_data[BIT_FLOAT];
                halt_sel <= wr_data[BIT_HLT_H:BIT_HLT_L];
            end
            if (irq)
                mode <= MODE_RUN;
            else if (any_req)
                mode <= next_entry;
        end
    end

endmodule

// File: rtl/pmc_rst_pulse.sv
// Module: pmc_rst_pulse
// Produces an internal reset pulse lasting RST_CYCLES clock cycles after a
// trigger. Triggers are expected only while idle (the caller masks them).
module pmc_rst_pulse #(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    // Load the pulse length on a trigger and count it down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (trig)
            cnt <= CW'(RST_CYCLES);
        else if (busy)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/pmc_halt_gate.sv
// Module: pmc_halt_gate
// Intermittent CPU operation: on each instruction-complete strobe it loads a
// down-counter with the selected halt length and holds the CPU clock enable
// low until the counter reaches zero. Lengths are HALT_BASE times 0, 1, 2, 4.
// The clear input (internal reset) empties the counter.
module pmc_halt_gate #(
    parameter int HALT_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       instr_done,
    input  logic [1:0] halt_sel,
    output logic       cpu_clk_en
);

    localparam int MAX_HALT = HALT_BASE * 4;
    localparam int CW       = $clog2(MAX_HALT + 1);

    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt;

    // Translate the 2-bit selector into a pulse count.
    always_comb begin
        case (halt_sel)
            2'b01:   load_val = CW'(HALT_BASE);
            2'b10:   load_val = CW'(HALT_BASE * 2);
            2'b11:   load_val = CW'(MAX_HALT);
            default: load_val = '0;
        endcase
    end

    // Halt counter: clear, load on a strobe, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (instr_done)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign cpu_clk_en = (cnt == '0);

endmodule

// File: rtl/pwr_mode_ctl.sv
// Module: pwr_mode_ctl (top)
// Low-power mode control register: decodes software writes into processor
// power modes, drives the pin-float enable, the internal reset pulse and the
// intermittent CPU clock enable. One machine cycle equals one clk cycle.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int RST_CYCLES = 3,
    parameter int HALT_BASE  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       irq,
    input  logic [1:0] clk_mode,
    input  logic       instr_done,
    output logic       stop_mode,
    output logic       sleep_mode,
    output logic       tbt_mode,
    output logic       pin_hiz,
    output logic       int_rst,
    output logic       cpu_clk_en
);

    pmc_mode_e  mode;
    logic       float_q;
    logic [1:0] halt_sel;
    logic       rst_trig;
    logic       rst_busy;

    pmc_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq      (irq),
        .clk_mode (clk_mode),
        .rst_busy (rst_busy),
        .mode     (mode),
        .float_q  (float_q),
        .halt_sel (halt_sel),
        .rst_trig (rst_trig)
    );

    pmc_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (rst_trig),
        .busy  (rst_busy)
    );

    pmc_halt_gate #(.HALT_BASE(HALT_BASE)) u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rst_busy),
        .instr_done (instr_done),
        .halt_sel   (halt_sel),
        .cpu_clk_en (cpu_clk_en)
    );

    // Decode the mode state into one flag per mode.
    always_comb begin
        stop_mode  = (mode == MODE_STOP);
        sleep_mode = (mode == MODE_SLEEP);
        tbt_mode   = (mode == MODE_TBT);
    end

    // Pins float only in the two deep modes and only when the flag asks.
    assign pin_hiz = float_q && (stop_mode || tbt_mode);
    assign int_rst = rst_busy;

    // Read view: trigger bits show their fixed values.
    always_comb begin
        rd_data                      = 8'h00;
        rd_data[BIT_FLOAT]           = float_q;
        rd_data[BIT_NRST]            = 1'b1;
        rd_data[BIT_NTBT]            = 1'b1;
        rd_data[BIT_HLT_H:BIT_HLT_L] = halt_sel;
    end

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
// Module: pwr_mode_ctl_chk
// Property checker for pwr_mode_ctl, attached by bind. Observes ports only.
module pwr_mode_ctl_chk #(
    parameter int RST_CYCLES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [1:0] clk_mode,
    input logic       instr_done,
    input logic       stop_mode,
    input logic       sleep_mode,
    input logic       tbt_mode,
    input logic       pin_hiz,
    input logic       int_rst,
    input logic       cpu_clk_en
);

    localparam int HW = $clog2(RST_CYCLES + 1) + 1;

    logic [HW-1:0] hi_cnt;

    // Count consecutive cycles of the internal reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (int_rst)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    assert_stop_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0);

    assert_sleep_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] == 1'b0);

    assert_tbt_clock_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbt_mode) |-> ($past(clk_mode) == 2'b00 || $past(clk_mode) == 2'b01));

    assert_irq_exits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!stop_mode && !sleep_mode && !tbt_mode));

    assert_float_deep_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz |-> (stop_mode || tbt_mode));

    assert_pulse_not_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> (hi_cnt < HW'(RST_CYCLES)));

    assert_pulse_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst) |-> (hi_cnt == HW'(RST_CYCLES)));

    assert_pulse_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> (!stop_mode && !sleep_mode && !tbt_mode && rd_data == 8'h18));

    assert_halt_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> $past(instr_done));

    assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4:3] == 2'b11) && (rd_data[0] == 1'b0));

    assert_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_mode, sleep_mode, tbt_mode}));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .irq        (irq),
    .clk_mode   (clk_mode),
    .instr_done (instr_done),
    .stop_mode  (stop_mode),
    .sleep_mode (sleep_mode),
    .tbt_mode   (tbt_mode),
    .pin_hiz    (pin_hiz),
    .int_rst    (int_rst),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/pwr_mode_ctl_tb_top.sv
// Directed testbench for pwr_mode_ctl: one task per scenario.
module pwr_mode_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;
    logic [1:0] clk_mode;
    logic       instr_done;
    logic       stop_mode;
    logic       sleep_mode;
    logic       tbt_mode;
    logic       pin_hiz;
    logic       int_rst;
    logic       cpu_clk_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .irq        (irq),
        .clk_mode   (clk_mode),
        .instr_done (instr_done),
        .stop_mode  (stop_mode),
        .sleep_mode (sleep_mode),
        .tbt_mode   (tbt_mode),
        .pin_hiz    (pin_hiz),
        .int_rst    (int_rst),
        .cpu_clk_en (cpu_clk_en)
    );

    // Compare one value and report a failure line.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pack the three mode outputs as {stop, sleep, tbt}.
    function automatic int modes();
        return {29'd0, stop_mode, sleep_mode, tbt_mode};
    endfunction

    // One-cycle register write; returns at the following negedge.
    task automatic wr(input logic [7:0] d, input logic with_irq = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; irq = with_irq;
        @(negedge clk);
        wr_en = 1'b0; irq = 1'b0;
    endtask

    // One-cycle interrupt request.
    task automatic pulse_irq();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "modes", modes(), 0);
        chk("R9", "rd_data", rd_data, 8'h18);
        chk("R9", "pin_hiz", pin_hiz, 0);
        chk("R9", "int_rst", int_rst, 0);
        chk("R9", "cpu_clk_en", cpu_clk_en, 1);
    endtask

    task automatic t_stop();
        wr(8'h98);
        chk("R1", "stop entered", modes(), 3'b100);
        chk("R1", "bit7 read", rd_data[7], 0);
        wr(8'h18);
        chk("R5", "stop kept on null write", modes(), 3'b100);
        pulse_irq();
        chk("R4", "irq exits stop", modes(), 0);
    endtask

    task automatic t_sleep();
        wr(8'h58);
        chk("R2", "sleep entered", modes(), 3'b010);
        chk("R2", "bit6 read", rd_data[6], 0);
        pulse_irq();
        chk("R4", "irq exits sleep", modes(), 0);
        wr(8'hD8);
        chk("R2", "stop over sleep", modes(), 3'b100);
        pulse_irq();
    endtask

    task automatic t_tbt();
        clk_mode = 2'b00;
        wr(8'h10);
        chk("R3", "tbt on main", modes(), 3'b001);
        chk("R3", "bit3 read", rd_data[3], 1);
        pulse_irq();
        clk_mode = 2'b01;
        wr(8'h10);
        chk("R3", "tbt on pll", modes(), 3'b001);
        pulse_irq();
        clk_mode = 2'b10;
        wr(8'h10);
        chk("R3", "tbt refused on sub", modes(), 0);
        clk_mode = 2'b11;
        wr(8'h10);
        chk("R3", "tbt refused on 11", modes(), 0);
        clk_mode = 2'b00;
    endtask

    task automatic t_irq_cancel();
        wr(8'h98, 1'b1);
        chk("R4", "entry cancelled", modes(), 0);
        wr(8'h58, 1'b1);
        chk("R4", "sleep cancelled", modes(), 0);
    endtask

    task automatic t_float();
        wr(8'hB8);
        chk("R6", "hiz in stop", pin_hiz, 1);
        pulse_irq();
        chk("R6", "no hiz in run", pin_hiz, 0);
        chk("R6", "flag kept", rd_data[5], 1);
        wr(8'h78);
        chk("R6", "no hiz in sleep", pin_hiz, 0);
        pulse_irq();
        wr(8'h30);
        chk("R6", "hiz in tbt", pin_hiz, 1);
        wr(8'h18);
        chk("R6", "flag cleared, no hiz", pin_hiz, 0);
        pulse_irq();
    endtask

    task automatic t_rst_pulse();
        wr(8'hBE);
        chk("R7", "pre state", {stop_mode, rd_data}, 9'h13E);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h08;
        @(negedge clk);
        chk("R7", "pulse c1", int_rst, 1);
        chk("R7", "state cleared", {modes(), rd_data}, 8'h18);
        chk("R7", "hiz dropped", pin_hiz, 0);
        wr_data = 8'h00;
        @(negedge clk);
        chk("R7", "pulse c2", int_rst, 1);
        wr_data = 8'h98;
        @(negedge clk);
        chk("R7", "pulse c3", int_rst, 1);
        chk("R7", "write ignored", {modes(), rd_data}, 8'h18);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R7", "pulse ended", int_rst, 0);
        chk("R7", "still run", modes(), 0);
        wr(8'h98);
        chk("R7", "writes work after", modes(), 3'b100);
        pulse_irq();
    endtask

    task automatic t_halt();
        for (int s = 0; s < 4; s++) begin
            int lows = 0;
            int exp  = (s == 0) ? 0 : (8 << (s - 1));
            wr({5'b00011, s[1:0], 1'b0});
            @(negedge clk);
            instr_done = 1'b1;
            @(negedge clk);
            instr_done = 1'b0;
            while (!cpu_clk_en && lows < 100) begin
                lows++;
                @(negedge clk);
            end
            chk("R8", "halt length", lows, exp);
        end
        wr(8'h18);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; irq = 1'b0;
        clk_mode = 2'b00; instr_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop();
        t_sleep();
        t_tbt();
        t_irq_cancel();
        t_float();
        t_rst_pulse();
        t_halt();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule